// File: doc/BRIEF.md
# Shared Address/Data Bus Target with Local Register File

This block is the responding side of a 32-bit synchronous bus on which one set of lines carries first an address and then data words. The initiator opens a transaction by pulling its frame line low. On that first framed clock the block captures the address and the 4-bit command. It decides whether the cycle belongs to it. A memory command claims the cycle when the address falls inside a fixed window. A configuration command claims it when a dedicated chip-select input is high.

Once it has claimed a cycle, the block drives device-select and target-ready. It moves one 32-bit word on every clock where the initiator is also ready. Each write is merged into a small register file under active-low byte enables. Reads are driven back on the data lines. In a burst the word pointer advances after every completed beat. When the burst reaches the last word of the file, the block signals stop together with that final beat, which disconnects the initiator.

Top module: `muxBusTarget`

## Requirements
- R1: After reset, devSelN, tgtRdyN and stopN are high, adBusOe is low, and every register-file word reads back as zero.
- R2: A transaction is claimed when its command is one of 0110 (memory read), 0111 (memory write), 1010 (configuration read) or 1011 (configuration write) and address bits [1:0] are 00. devSelN goes low on the clock after the address phase, and tgtRdyN is never low while devSelN is high.
- R3: Any other command, and any memory command whose address bits [31:6] differ from the window base (default 0x0001_0000, 16 words), is not claimed. devSelN stays high and no register changes.
- R4: A configuration command is claimed only if chipSelCfg is high in the address phase, whatever the upper address bits. Without chipSelCfg it is not claimed.
- R5: A data word moves only on a clock where both initRdyN and tgtRdyN are low. A clock with initRdyN high is a wait state that leaves the word pointer unchanged.
- R6: On a write beat, byte lane i (bits 8i+7..8i) is updated only when cmdBeN[i] is 0.
- R7: The word index is taken from address bits [5:2] and advances by one word (address +4) after each completed beat of a burst.
- R8: A beat that completes while frameN is high is the last one. On the next clock devSelN and tgtRdyN are high.
- R9: stopN is low together with tgtRdyN on a beat at word index 15. If that beat completes with frameN still low, the block then holds devSelN and stopN low with tgtRdyN high until it samples frameN high, and then releases both.
- R10: During read data phases the addressed word is driven on adBusOut, with adBusOe high only while tgtRdyN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| adBusIn | input | 32 | Shared address/data lines as received |
| adBusOut | output | 32 | Read data to drive on the shared lines |
| adBusOe | output | 1 | Drive enable for adBusOut |
| cmdBeN | input | 4 | Command in address phase, active-low byte enables in data phases |
| frameN | input | 1 | Active-low transaction frame from the initiator |
| initRdyN | input | 1 | Active-low initiator ready |
| chipSelCfg | input | 1 | Select for configuration transactions |
| devSelN | output | 1 | Active-low claim of the transaction |
| tgtRdyN | output | 1 | Active-low target ready |
| stopN | output | 1 | Active-low request to end the transaction |

## Verification
On every clock the assertions check how the handshake outputs relate to one another. Target-ready and stop never appear without device-select, and read drive appears only with target-ready. A claim follows only a framed clock. Unknown commands and configuration cycles without the select line are never claimed. After a final beat the block releases the bus, and the disconnect hand-off holds and then releases on frame withdrawal. Only the bench scenarios can show what ends up in the register file. That covers byte-lane merging, the pointer advancing across wait states, words left untouched by unclaimed cycles, and the exact number of beats accepted before a disconnect.

// File: rtl/tgtBusPkg.sv
package tgtBusPkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_BACKOFF,
    ST_IGNORE
  } tgtStateE;

  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic writeBeat;
  } dpStrobeT;

endpackage

// File: rtl/tgtDatapath.sv
module tgtDatapath
  import tgtBusPkg::*;
#(
  parameter int          WORDS    = 16,
  parameter logic [31:0] WIN_BASE = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adBusIn,
  input  logic [3:0]  cmdBeN,
  input  logic        chipSelCfg,
  input  dpStrobeT    strobe,
  output logic        addrHit,
  output logic        cmdIsRead,
  output logic        atLast,
  output logic [31:0] rdWord
);
  localparam int IDXW    = $clog2(WORDS);
  localparam int WIN_LSB = IDXW + 2;
  localparam int LANES   = 4;

  logic [IDXW-1:0]  wordIdx;
  logic [31:0]      memArr [WORDS];
  logic [LANES-1:0] laneWr;
  logic             memCmd;
  logic             cfgCmd;
  logic             winMatch;
  logic             aligned;

  // address-phase decode, evaluated on the raw bus lines
  always_comb begin
    memCmd   = (cmdBeN == CMD_MEM_RD) || (cmdBeN == CMD_MEM_WR);
    cfgCmd   = (cmdBeN == CMD_CFG_RD) || (cmdBeN == CMD_CFG_WR);
    winMatch = (adBusIn[31:WIN_LSB] == WIN_BASE[31:WIN_LSB]);
    aligned  = (adBusIn[1:0] == 2'b00);
    addrHit  = aligned && ((memCmd && winMatch) || (cfgCmd && chipSelCfg));
  end

  // word pointer and captured direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx   <= '0;
      cmdIsRead <= 1'b0;
    end else if (strobe.loadAddr) begin
      wordIdx   <= adBusIn[WIN_LSB-1:2];
      cmdIsRead <= !cmdBeN[0];
    end else if (strobe.incAddr) begin
      wordIdx   <= wordIdx + IDXW'(1);
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneWr[b] = strobe.writeBeat && !cmdBeN[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) memArr[w] <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < LANES; b++) begin
          if (laneWr[b] && (wordIdx == IDXW'(w)))
            memArr[w][b*8 +: 8] <= adBusIn[b*8 +: 8];
        end
      end
    end
  end

  assign rdWord = memArr[wordIdx];
  assign atLast = (wordIdx == IDXW'(WORDS - 1));

endmodule

// File: rtl/tgtCtrl.sv
module tgtCtrl
  import tgtBusPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameN,
  input  logic     initRdyN,
  input  logic     addrHit,
  input  logic     atLast,
  input  logic     cmdIsRead,
  output dpStrobeT strobe,
  output logic     devSelN,
  output logic     tgtRdyN,
  output logic     stopN,
  output logic     adBusOe
);
  tgtStateE state;
  tgtStateE stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!frameN) begin
          if (addrHit) begin
            strobe.loadAddr = 1'b1;
            stateNext       = ST_DATA;
          end else begin
            stateNext = ST_IGNORE;
          end
        end
      end
      ST_DATA: begin
        if (!initRdyN) begin
          strobe.writeBeat = !cmdIsRead;
          if (frameN)      stateNext = ST_IDLE;
          else if (atLast) stateNext = ST_BACKOFF;
          else             strobe.incAddr = 1'b1;
        end else if (frameN) begin
          stateNext = ST_IDLE;
        end
      end
      ST_BACKOFF: if (frameN) stateNext = ST_IDLE;
      ST_IGNORE:  if (frameN) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  // handshake outputs decoded from registered state only
  assign devSelN = !((state == ST_DATA) || (state == ST_BACKOFF));
  assign tgtRdyN = !(state == ST_DATA);
  assign stopN   = !(((state == ST_DATA) && atLast) || (state == ST_BACKOFF));
  assign adBusOe = (state == ST_DATA) && cmdIsRead;

endmodule

// File: rtl/muxBusTarget.sv
module muxBusTarget
  import tgtBusPkg::*;
#(
  parameter int          WORDS    = 16,
  parameter logic [31:0] WIN_BASE = 32'h0001_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adBusIn,
  output logic [31:0] adBusOut,
  output logic        adBusOe,
  input  logic [3:0]  cmdBeN,
  input  logic        frameN,
  input  logic        initRdyN,
  input  logic        chipSelCfg,
  output logic        devSelN,
  output logic        tgtRdyN,
  output logic        stopN
);
  dpStrobeT    strobe;
  logic        addrHit;
  logic        cmdIsRead;
  logic        atLast;
  logic [31:0] rdWord;

  tgtCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .initRdyN (initRdyN),
    .addrHit  (addrHit),
    .atLast   (atLast),
    .cmdIsRead(cmdIsRead),
    .strobe   (strobe),
    .devSelN  (devSelN),
    .tgtRdyN  (tgtRdyN),
    .stopN    (stopN),
    .adBusOe  (adBusOe)
  );

  tgtDatapath #(.WORDS(WORDS), .WIN_BASE(WIN_BASE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .adBusIn   (adBusIn),
    .cmdBeN    (cmdBeN),
    .chipSelCfg(chipSelCfg),
    .strobe    (strobe),
    .addrHit   (addrHit),
    .cmdIsRead (cmdIsRead),
    .atLast    (atLast),
    .rdWord    (rdWord)
  );

  assign adBusOut = adBusOe ? rdWord : '0;

endmodule

// File: rtl/muxBusTargetChecker.sv
module muxBusTargetChecker
  import tgtBusPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cmdBeN,
  input logic       frameN,
  input logic       initRdyN,
  input logic       chipSelCfg,
  input logic       devSelN,
  input logic       tgtRdyN,
  input logic       stopN,
  input logic       adBusOe
);
  logic knownCmd;
  logic cfgCmd;
  assign cfgCmd   = (cmdBeN == CMD_CFG_RD) || (cmdBeN == CMD_CFG_WR);
  assign knownCmd = cfgCmd || (cmdBeN == CMD_MEM_RD) || (cmdBeN == CMD_MEM_WR);

  assert_trdy_with_devsel_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tgtRdyN |-> !devSelN);

  assert_claim_after_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devSelN) |-> $past(!frameN));

  assert_unknown_cmd_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && $past(frameN) && !knownCmd) |=> devSelN);

  assert_cfg_needs_select_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!frameN && $past(frameN) && cfgCmd && !chipSelCfg) |=> devSelN);

  assert_final_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && !initRdyN && !tgtRdyN) |=> (devSelN && tgtRdyN));

  assert_stop_needs_devsel_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stopN |-> !devSelN);

  assert_disconnect_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && !tgtRdyN && !initRdyN && !frameN) |=> (!devSelN && !stopN && tgtRdyN));

  assert_disconnect_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stopN && tgtRdyN && frameN) |=> (stopN && devSelN));

  assert_read_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    adBusOe |-> !tgtRdyN);

endmodule

bind muxBusTarget muxBusTargetChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdBeN    (cmdBeN),
  .frameN    (frameN),
  .initRdyN  (initRdyN),
  .chipSelCfg(chipSelCfg),
  .devSelN   (devSelN),
  .tgtRdyN   (tgtRdyN),
  .stopN     (stopN),
  .adBusOe   (adBusOe)
);

// File: tb/muxBusTarget_tb.sv
module muxBusTarget_tb;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] adIn;
  logic [31:0] adBusOut;
  logic        adBusOe;
  logic [3:0]  cmdBeN;
  logic        frameN;
  logic        initRdyN;
  logic        chipSel;
  logic        devSelN;
  logic        tgtRdyN;
  logic        stopN;

  int checkCount = 0;
  int failCount  = 0;

  logic [31:0] shadow [16];
  logic [31:0] txData [8];
  logic [3:0]  txBe   [8];
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = !clk;

  muxBusTarget u_dut (
    .clk(clk), .rstN(rstN), .adBusIn(adIn), .adBusOut(adBusOut), .adBusOe(adBusOe),
    .cmdBeN(cmdBeN), .frameN(frameN), .initRdyN(initRdyN), .chipSelCfg(chipSel),
    .devSelN(devSelN), .tgtRdyN(tgtRdyN), .stopN(stopN)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read words as beats complete
  always @(negedge clk) begin
    #1;
    if (rstN && !initRdyN && !tgtRdyN && adBusOe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected read beat", adBusOut, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(adBusOut == e, t, adBusOut, e);
      end
    end
  end

  task automatic runTxn(input logic [3:0] cmd, input logic [31:0] addr, input bit cs,
                        input int n, input int waitAt, input string tag,
                        output int done, output bit claimedFirst, output bit everClaimed,
                        output bit stopOk, output bit releaseOk);
    int cyc;
    bit xfer;
    bit stopSeen;
    bit lastBeat;
    bit isWr;
    int idx;
    isWr = cmd[0];
    @(negedge clk);
    frameN = 1'b0; adIn = addr; cmdBeN = cmd; chipSel = cs; initRdyN = 1'b1;
    @(negedge clk);
    claimedFirst = !devSelN;
    everClaimed = 1'b0; done = 0; cyc = 0; stopOk = 1'b0; releaseOk = 1'b0;
    chipSel = 1'b0;
    while (done < n && cyc < 12) begin
      bit waitNow;
      waitNow  = (cyc == waitAt);
      idx      = (int'(addr[5:2]) + done) % 16;
      adIn     = isWr ? txData[done] : 32'h0;
      cmdBeN   = txBe[done];
      initRdyN = waitNow;
      frameN   = !waitNow && (done == n - 1);
      if (!devSelN) everClaimed = 1'b1;
      xfer     = !initRdyN && !tgtRdyN;
      stopSeen = !stopN;
      lastBeat = frameN;
      if (xfer && isWr) begin
        for (int b = 0; b < 4; b++)
          if (!txBe[done][b]) shadow[idx][b*8 +: 8] = txData[done][b*8 +: 8];
      end
      if (xfer && !isWr) begin
        expQ.push_back(shadow[idx]);
        tagQ.push_back(tag);
      end
      @(negedge clk);
      cyc++;
      if (xfer) begin
        done++;
        if (lastBeat) begin
          releaseOk = devSelN && tgtRdyN;
          break;
        end
        if (stopSeen) begin
          stopOk = !devSelN && tgtRdyN && !stopN;
          frameN = 1'b1; initRdyN = 1'b1;
          @(negedge clk);
          stopOk = stopOk && devSelN && stopN;
          break;
        end
      end
      if (cyc >= 4 && !everClaimed) break;
    end
    frameN = 1'b1; initRdyN = 1'b1; adIn = 32'h0; cmdBeN = 4'hF;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    int  done;
    bit  cf, ec, so, ro;
    for (int i = 0; i < 16; i++) shadow[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin txData[i] = 32'h0; txBe[i] = 4'h0; end
    rstN = 1'b0; frameN = 1'b1; initRdyN = 1'b1; adIn = 32'h0; cmdBeN = 4'hF; chipSel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle outputs in reset
    check(devSelN && tgtRdyN && stopN && !adBusOe, "R1 idle outputs",
          {28'h0, devSelN, tgtRdyN, stopN, adBusOe}, 32'hE);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R7: zeroed file read as a burst
    runTxn(4'b0110, BASE, 1'b0, 4, 99, "R1 reset word", done, cf, ec, so, ro);
    check(cf, "R2 claim on clock after address", {31'h0, cf}, 32'h1);
    check(done == 4, "R7 burst beats", done, 4);

    // R5 / R7: write burst with an initiator wait state, read back with another
    for (int i = 0; i < 4; i++) begin txData[i] = 32'hA500_0000 + i * 32'h0101; txBe[i] = 4'h0; end
    runTxn(4'b0111, BASE + 32'd16, 1'b0, 4, 1, "R5", done, cf, ec, so, ro);
    check(done == 4, "R5 beats with wait", done, 4);
    runTxn(4'b0110, BASE + 32'd16, 1'b0, 4, 2, "R7 burst increment readback", done, cf, ec, so, ro);
    check(done == 4, "R7 read beats", done, 4);

    // R8 / R6: full write then partial byte-lane write
    txData[0] = 32'h1122_3344; txBe[0] = 4'h0;
    runTxn(4'b0111, BASE + 32'd8, 1'b0, 1, 99, "R8", done, cf, ec, so, ro);
    check(ro, "R8 release after final beat", {31'h0, ro}, 32'h1);
    txData[0] = 32'hAABB_CCDD; txBe[0] = 4'b1010;
    runTxn(4'b0111, BASE + 32'd8, 1'b0, 1, 99, "R6", done, cf, ec, so, ro);
    check(shadow[2] == 32'h11BB_33DD, "R6 lane model", shadow[2], 32'h11BB_33DD);
    txBe[0] = 4'h0;
    runTxn(4'b0110, BASE + 32'd8, 1'b0, 1, 99, "R6 byte-lane merge", done, cf, ec, so, ro);

    // R3: unsupported command and out-of-window address
    txData[0] = 32'hDEAD_BEEF; txBe[0] = 4'h0;
    runTxn(4'b0011, BASE + 32'd12, 1'b0, 1, 99, "R3", done, cf, ec, so, ro);
    check(!ec, "R3 unknown command not claimed", {31'h0, ec}, 32'h0);
    runTxn(4'b0111, BASE + 32'h1000, 1'b0, 2, 99, "R3", done, cf, ec, so, ro);
    check(!ec && done == 0, "R3 outside window not claimed", done, 0);
    runTxn(4'b0110, BASE, 1'b0, 4, 99, "R3 words untouched", done, cf, ec, so, ro);

    // R4: configuration cycles gated by chip select
    txData[0] = 32'h0C0F_1600; txBe[0] = 4'h0;
    runTxn(4'b1011, 32'hDEAD_0000 | 32'd28, 1'b1, 1, 99, "R4", done, cf, ec, so, ro);
    check(cf && done == 1, "R4 config write claimed", done, 1);
    runTxn(4'b1010, 32'h0BAD_0000 | 32'd28, 1'b1, 1, 99, "R4 config readback", done, cf, ec, so, ro);
    txData[0] = 32'h5555_5555;
    runTxn(4'b1011, 32'd32, 1'b0, 1, 99, "R4", done, cf, ec, so, ro);
    check(!ec, "R4 config without select ignored", {31'h0, ec}, 32'h0);
    runTxn(4'b0110, BASE + 32'd32, 1'b0, 1, 99, "R4 unselected word untouched", done, cf, ec, so, ro);

    // R9: bursts that run into the end of the file
    for (int i = 0; i < 4; i++) begin txData[i] = 32'h7700_0000 + i; txBe[i] = 4'h0; end
    runTxn(4'b0111, BASE + 32'd56, 1'b0, 4, 99, "R9", done, cf, ec, so, ro);
    check(done == 2, "R9 write disconnect beats", done, 2);
    check(so, "R9 disconnect hold and release", {31'h0, so}, 32'h1);
    runTxn(4'b0110, BASE + 32'd56, 1'b0, 3, 99, "R9 readback", done, cf, ec, so, ro);
    check(done == 2 && so, "R9 read disconnect", done, 2);
    runTxn(4'b0110, BASE, 1'b0, 1, 99, "R9 word 0 not wrapped", done, cf, ec, so, ro);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all reads observed", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule